// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a free-running nanosecond time of day for packet timestamping. On every tick of its reference clock the nanosecond count moves forward by a fixed nominal step of 8 ns. A 32-bit fraction accumulator sits below the nanosecond count. Software trims the rate with a sign-magnitude value that the accumulator adds or subtracts once per tick. When the accumulator carries, that tick advances one extra nanosecond. When it borrows, that tick advances one nanosecond less.

Software reaches the block through a plain 32-bit register port with five word addresses. The time is split across three words: the live fraction, nanoseconds 31:0 and nanoseconds 39:32. A read of the fraction word freezes the whole nanosecond value into a shadow copy, so the two nanosecond words always read back as one coherent sample. A time step works the same way. The low word is staged first, and writing the high word applies the complete value in a single update. Capture logic elsewhere takes the live nanosecond count from a dedicated output bus.

Top module: `frac_tod_counter`

## Requirements
- R1: After reset the nanosecond output is 0, the trim reads 0, the fraction and both shadow words read 0, and the control word (address 0) reads 0x8000_0000.
- R2: Only bit 31 of the control word is stored and the other bits read 0. While bit 31 is 1 the time does not change.
- R3: A write of 0 to the control word takes effect at its own clock edge. From the following edge onward, each edge adds 8 ns when the trim magnitude is 0, and a trim of 0x8000_0000 (negative zero) behaves the same as a trim of 0.
- R4: With trim bit 31 = 0 (address 1), each tick adds trim[30:0] to the fraction. A carry out of bit 31 makes that tick advance 9 ns instead of 8.
- R5: With trim bit 31 = 1, each tick subtracts trim[30:0] from the fraction. A borrow makes that tick advance 7 ns instead of 8.
- R6: The nanosecond count is 40 bits wide and wraps modulo 2^40.
- R7: A read of the fraction word (address 2) returns the live fraction and, at the same edge, copies the nanosecond count into a shadow. Later reads of address 3 (bits 31:0) and address 4 (bits 39:32) return that copy while the time keeps running.
- R8: Reads of address 4 return 0 in bits 31:8. Writes to address 4 keep only bits 7:0.
- R9: A write to address 3 only stages the low nanoseconds and leaves the time unchanged. A write to address 4 loads the staged 40-bit value on the next clock edge, clears the fraction at that edge, and takes priority over counting.
- R10: A read with `regRdEn` returns its data on `regRdData` at the next clock edge, and the trim word reads back exactly as written.
- R11: Writes to the fraction word have no effect on the fraction or the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one tick per edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 3 | Word address: 0 control, 1 trim, 2 fraction, 3 ns low, 4 ns high |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, registered |
| timeNsOut | output | 40 | Live nanosecond count for capture logic |

## Verification
Each result has a fixed latency. A control-word write changes the run state at its own edge, so counting starts one edge later. A high-word write produces the new time one edge after the write edge. Read data and the shadow copy both update at the read edge.

The bench drives inputs on falling edges and samples on the falling edge right after the edge that is due. It also samples once before that edge to show the value has not yet moved. The table vectors run an exact number of counting edges, and the expected nanosecond and fraction values for each vector are worked out by hand.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  localparam int NS_W       = 40;
  localparam int FRAC_W     = 32;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 3;
  localparam int NOMINAL_NS = 8;
  localparam int HI_W       = NS_W - REG_W;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_RATE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FRAC = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_NSLO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_NSHI = 3'd4;

  typedef struct packed {
    logic              run;
    logic              load;
    logic              rateSub;
    logic [FRAC_W-2:0] rateMag;
    logic [NS_W-1:0]   loadNs;
  } tickCtl_t;
endpackage

// File: rtl/ptpc_datapath.sv
module ptpc_datapath
  import ptpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tickCtl_t          ctl,
  output logic [NS_W-1:0]   nsQ,
  output logic [FRAC_W-1:0] fracQ
);
  logic [FRAC_W:0]   fracSum;
  logic [FRAC_W:0]   fracDiff;
  logic              carry;
  logic              borrow;
  logic [FRAC_W-1:0] fracNext;
  logic [NS_W-1:0]   nsIncr;

  always_comb begin
    fracSum  = {1'b0, fracQ} + {2'b00, ctl.rateMag};
    fracDiff = {1'b0, fracQ} - {2'b00, ctl.rateMag};
    carry    = !ctl.rateSub && fracSum[FRAC_W];
    borrow   = ctl.rateSub && fracDiff[FRAC_W];
    fracNext = ctl.rateSub ? fracDiff[FRAC_W-1:0] : fracSum[FRAC_W-1:0];
    nsIncr   = NS_W'(NOMINAL_NS) + NS_W'(carry) - NS_W'(borrow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nsQ   <= '0;
      fracQ <= '0;
    end else if (ctl.load) begin
      nsQ   <= ctl.loadNs;
      fracQ <= '0;
    end else if (ctl.run) begin
      nsQ   <= nsQ + nsIncr;
      fracQ <= fracNext;
    end
  end
endmodule

// File: rtl/ptpc_ctrl.sv
module ptpc_ctrl
  import ptpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [NS_W-1:0]   nsNow,
  input  logic [FRAC_W-1:0] fracNow,
  output tickCtl_t          ctl
);
  logic              haltQ;
  logic [REG_W-1:0]  rateQ;
  logic [NS_W-1:0]   shadowNs;
  logic [NS_W-1:0]   stageNs;
  logic              loadPendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltQ     <= 1'b1;
      rateQ     <= '0;
      stageNs   <= '0;
      loadPendQ <= 1'b0;
    end else begin
      loadPendQ <= 1'b0;
      if (regWrEn) begin
        case (regAddr)
          ADDR_CTRL: haltQ <= regWrData[REG_W-1];
          ADDR_RATE: rateQ <= regWrData;
          ADDR_NSLO: stageNs[REG_W-1:0] <= regWrData;
          ADDR_NSHI: begin
            stageNs[NS_W-1:REG_W] <= regWrData[HI_W-1:0];
            loadPendQ             <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowNs  <= '0;
      regRdData <= '0;
    end else if (regRdEn) begin
      case (regAddr)
        ADDR_CTRL: regRdData <= {haltQ, {(REG_W-1){1'b0}}};
        ADDR_RATE: regRdData <= rateQ;
        ADDR_FRAC: begin
          regRdData <= REG_W'(fracNow);
          shadowNs  <= nsNow;
        end
        ADDR_NSLO: regRdData <= shadowNs[REG_W-1:0];
        ADDR_NSHI: regRdData <= REG_W'(shadowNs[NS_W-1:REG_W]);
        default:   regRdData <= '0;
      endcase
    end
  end

  always_comb begin
    ctl.run     = !haltQ;
    ctl.load    = loadPendQ;
    ctl.rateSub = rateQ[REG_W-1];
    ctl.rateMag = rateQ[FRAC_W-2:0];
    ctl.loadNs  = stageNs;
  end
endmodule

// File: rtl/frac_tod_counter.sv
module frac_tod_counter
  import ptpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic [NS_W-1:0]   timeNsOut
);
  tickCtl_t          tickCtl;
  logic [FRAC_W-1:0] fracNow;

  ptpc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .nsNow(timeNsOut), .fracNow(fracNow), .ctl(tickCtl)
  );

  ptpc_datapath i_datapath (
    .clk(clk), .rstN(rstN), .ctl(tickCtl),
    .nsQ(timeNsOut), .fracQ(fracNow)
  );
endmodule

// File: rtl/ptpc_checker.sv
module ptpc_checker
  import ptpc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regRdData,
  input logic [NS_W-1:0]   timeNsOut,
  input logic [FRAC_W-1:0] fracNow,
  input tickCtl_t          ctl
);
  p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run && !ctl.load) |=> $stable(timeNsOut));

  p_nominal_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !ctl.load && ctl.rateMag == '0) |=>
      (timeNsOut == $past(timeNsOut) + NS_W'(NOMINAL_NS)));

  p_trim_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !ctl.load) |=>
      ((timeNsOut - $past(timeNsOut)) == NS_W'(NOMINAL_NS - 1) ||
       (timeNsOut - $past(timeNsOut)) == NS_W'(NOMINAL_NS) ||
       (timeNsOut - $past(timeNsOut)) == NS_W'(NOMINAL_NS + 1)));

  p_hi_reserved_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_NSHI) |=> (regRdData[REG_W-1:HI_W] == '0));

  p_load_follows_hi_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_NSHI) |=> ctl.load);

  p_load_apply_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (timeNsOut == $past(ctl.loadNs) && fracNow == '0));
endmodule

bind frac_tod_counter ptpc_checker i_checker (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regRdData(regRdData), .timeNsOut(timeNsOut),
  .fracNow(fracNow), .ctl(tickCtl)
);

// File: tb/test_frac_tod_counter.sv
module test_frac_tod_counter;
  import ptpc_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [REG_W-1:0]  regWrData = '0;
  logic [REG_W-1:0]  regRdData;
  logic [NS_W-1:0]   timeNsOut;

  int  testCount = 0;
  int  failCount = 0;
  bit  finished  = 1'b0;

  always #2 clk = ~clk;

  frac_tod_counter i_frac_tod_counter (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .timeNsOut(timeNsOut)
  );

  typedef struct packed {
    logic [31:0] trim;
    logic [7:0]  ticks;
    logic [39:0] expNs;
    logic [31:0] expFrac;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 8'd5, 40'd40, 32'h0000_0000},
    '{32'h4000_0000, 8'd5, 40'd41, 32'h4000_0000},
    '{32'hC000_0000, 8'd5, 40'd38, 32'hC000_0000},
    '{32'h7FFF_FFFF, 8'd3, 40'd25, 32'h7FFF_FFFD},
    '{32'hFFFF_FFFF, 8'd3, 40'd22, 32'h8000_0003},
    '{32'h8000_0000, 8'd4, 40'd32, 32'h0000_0000}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] v);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    v = regRdData;
  endtask

  task automatic loadTime(input logic [NS_W-1:0] v);
    writeReg(ADDR_NSLO, v[31:0]);
    writeReg(ADDR_NSHI, {24'h0, v[39:32]});
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [REG_W-1:0] rv;
    logic [NS_W-1:0]  captured;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "ns after reset", 64'(timeNsOut), 64'h0);
    readReg(ADDR_CTRL, rv); check("R1", "control word", 64'(rv), 64'h8000_0000);
    readReg(ADDR_RATE, rv); check("R1", "trim", 64'(rv), 64'h0);
    readReg(ADDR_FRAC, rv); check("R1", "fraction", 64'(rv), 64'h0);
    readReg(ADDR_NSLO, rv); check("R1", "shadow low", 64'(rv), 64'h0);
    readReg(ADDR_NSHI, rv); check("R1", "shadow high", 64'(rv), 64'h0);

    // R2 halted counter holds; reserved control bits read zero
    repeat (10) @(negedge clk);
    check("R2", "ns while halted", 64'(timeNsOut), 64'h0);
    writeReg(ADDR_CTRL, 32'hFFFF_FFFF);
    readReg(ADDR_CTRL, rv); check("R2", "control reserved bits", 64'(rv), 64'h8000_0000);
    repeat (4) @(negedge clk);
    check("R2", "ns still halted", 64'(timeNsOut), 64'h0);

    // Vector table: R3 / R4 / R5 by trim sign and magnitude
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = (VECS[i].trim[30:0] == '0) ? "R3" : (VECS[i].trim[31] ? "R5" : "R4");
      loadTime('0);
      writeReg(ADDR_RATE, VECS[i].trim);
      writeReg(ADDR_CTRL, 32'h0);
      repeat (int'(VECS[i].ticks) - 1) @(negedge clk);
      writeReg(ADDR_CTRL, 32'h8000_0000);
      check(tag, $sformatf("vector %0d ns", i), 64'(timeNsOut), 64'(VECS[i].expNs));
      readReg(ADDR_FRAC, rv);
      check(tag, $sformatf("vector %0d fraction", i), 64'(rv), 64'(VECS[i].expFrac));
    end

    // R10 trim readback with one-edge latency
    writeReg(ADDR_RATE, 32'hC000_1234);
    readReg(ADDR_RATE, rv); check("R10", "trim readback", 64'(rv), 64'hC000_1234);

    // R3 first count edge follows the start edge
    writeReg(ADDR_RATE, 32'h0);
    loadTime(40'd100);
    writeReg(ADDR_CTRL, 32'h0);
    check("R3", "no count at start edge", 64'(timeNsOut), 64'd100);
    @(negedge clk);
    check("R3", "first count", 64'(timeNsOut), 64'd108);
    writeReg(ADDR_CTRL, 32'h8000_0000);

    // R6 wrap at 2^40
    loadTime(40'hFF_FFFF_FFF8);
    writeReg(ADDR_CTRL, 32'h0);
    @(negedge clk);
    writeReg(ADDR_CTRL, 32'h8000_0000);
    check("R6", "wrap", 64'(timeNsOut), 64'h8);

    // R8 high word keeps 8 bits; reserved bits read zero
    loadTime({8'h12, 32'h0000_0100});
    writeReg(ADDR_NSHI, 32'hABCD_EF12);
    @(negedge clk);
    check("R8", "load with wide high write", 64'(timeNsOut), 64'h12_0000_0100);
    readReg(ADDR_FRAC, rv);
    readReg(ADDR_NSHI, rv); check("R8", "high word read", 64'(rv), 64'h12);
    readReg(ADDR_NSLO, rv); check("R8", "low word read", 64'(rv), 64'h100);

    // R7 coherent shadow while running
    loadTime(40'h0);
    writeReg(ADDR_CTRL, 32'h0);
    repeat (3) @(negedge clk);
    captured = timeNsOut;
    readReg(ADDR_FRAC, rv);
    repeat (4) @(negedge clk);
    readReg(ADDR_NSLO, rv); check("R7", "shadow low held", 64'(rv), 64'(captured[31:0]));
    readReg(ADDR_NSHI, rv); check("R7", "shadow high held", 64'(rv), 64'(captured[39:32]));
    check("R7", "time kept running", 64'(timeNsOut != captured), 64'h1);
    writeReg(ADDR_CTRL, 32'h8000_0000);

    // R9 staged step-write and fraction clear
    loadTime(40'h0);
    writeReg(ADDR_RATE, 32'h4000_0000);
    writeReg(ADDR_CTRL, 32'h0);
    writeReg(ADDR_CTRL, 32'h8000_0000);
    check("R9", "setup ns", 64'(timeNsOut), 64'd8);
    writeReg(ADDR_NSLO, 32'h0000_1234);
    @(negedge clk);
    check("R9", "low write alone", 64'(timeNsOut), 64'd8);
    writeReg(ADDR_NSHI, 32'h0);
    check("R9", "not yet loaded", 64'(timeNsOut), 64'd8);
    @(negedge clk);
    check("R9", "loaded", 64'(timeNsOut), 64'h1234);
    readReg(ADDR_FRAC, rv); check("R9", "fraction cleared", 64'(rv), 64'h0);

    // R11 fraction write ignored
    writeReg(ADDR_FRAC, 32'hDEAD_BEEF);
    readReg(ADDR_FRAC, rv); check("R11", "fraction after write", 64'(rv), 64'h0);
    check("R11", "ns after fraction write", 64'(timeNsOut), 64'h1234);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule